// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Word Status-Tagged Queue

This block receives asynchronous serial frames. A frame is one start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. An external divider supplies a single-cycle sample strobe at 16 times the bit rate. Every bit, the start bit included, is decided by a majority vote of three samples taken around the middle of the bit. When the stop bit has been decided, the assembled word moves into a two-entry queue. The queue entry also keeps that frame's ninth bit and its framing-error indication.

The host sees the head entry of the queue at all times: its data byte, ninth bit and framing-error bit. A pop strobe discards the head entry, so the status of a word has to be read before that word is popped. A data-available flag shows that the queue is not empty. That flag, gated with an interrupt enable, gives the interrupt output. If a frame completes while both entries are occupied, the sticky overrun flag is set and the frame is lost. While overrun is set, no further word enters the queue. Dropping the receive enable resets the bit-level receiver and clears overrun. The queue contents stay in place.

Top module: `uart_rx2q`

## Requirements
- R1: After synchronous reset, rx_flag, overrun and irq are all 0.
- R2: A frame with start bit low, data bits least significant first, and stop bit high is delivered at rd_data, and rx_flag becomes 1.
- R3: With nine_en=1 the bit received after the eighth data bit appears on rd_bit9. With nine_en=0, rd_bit9 reads 0.
- R4: A low pulse on rx_in that has ended before samples 7 to 9 of the start bit (sample 0 being the first low sample) is treated as a false start, and no word is produced.
- R5: A single inverted sample at sample 8 of a data bit does not change the decided value of that bit.
- R6: A stop bit decided low sets rd_ferr for that word only.
- R7: The queue holds two words in arrival order. A pop exposes the next entry's data, ninth bit and framing-error bit together.
- R8: A frame that completes while two words are queued sets overrun and is discarded. The queued words are kept unchanged.
- R9: While overrun is 1, completed frames never enter the queue, even after the queue has been emptied.
- R10: While rx_en is 0, no frame is received and overrun reads 0 from the next cycle on.
- R11: irq equals int_en AND rx_flag. rx_flag returns to 0 once pops have emptied the queue.
- R12: A pop while the queue is empty has no effect: rx_flag stays 0 and the next word is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe at OVS times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable; low resets the receiver and clears overrun |
| nine_en | input | 1 | Selects 9 data bits per frame |
| int_en | input | 1 | Interrupt enable |
| pop | input | 1 | Discards the head word of the queue |
| rd_data | output | DATA_W | Head word data |
| rd_bit9 | output | 1 | Head word ninth bit |
| rd_ferr | output | 1 | Head word framing error |
| rx_flag | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default DATA_W=8 and OVS=16. With these values the vote falls on samples 7, 8 and 9. A single-sample glitch and a five-sample false start can therefore be placed exactly at or ahead of the voting window. The strobe arrives every fourth clock, so each sample covers several cycles. This leaves room for the synchronizer delay and makes the sample position of every driven value exact. Nine-bit frames exercise the widest word, and an overrun/recovery sequence runs both queue entries through full, lost-frame and re-enable states.

// File: rtl/uart_rx2q.sv
module uart_rx2q #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              nine_en,
  input  logic              int_en,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rx_flag,
  output logic              overrun,
  output logic              irq
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam int SW  = DATA_W + 1;
  localparam int EW  = DATA_W + 2;
  localparam int BW  = $clog2(DATA_W + 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [1:0]    rx_sync;
  logic [2:0]    vote;
  logic          prev;
  logic [SW-1:0] sr;
  logic [EW-1:0] ent0, ent1;
  logic [1:0]    fcnt;
  logic          busy;

  wire           rx_s    = rx_sync[1];
  wire [2:0]     vnext   = {vote[1:0], rx_s};
  wire           maj     = (vnext[0] & vnext[1]) | (vnext[0] & vnext[2]) | (vnext[1] & vnext[2]);
  wire           at_vote = (cnt == CW'(MID + 1));
  wire           at_end  = (cnt == CW'(OVS - 1));
  wire [BW-1:0]  last    = nine_en ? BW'(DATA_W) : BW'(DATA_W - 1);
  wire           done    = rx_en && tick && (state == S_STOP) && at_vote;
  wire           full    = (fcnt == 2'd2);
  wire           push    = done && !overrun && !full;
  wire           pop_ok  = pop && (fcnt != 2'd0);
  wire [EW-1:0]  word    = nine_en ? {!maj, sr[DATA_W], sr[DATA_W-1:0]}
                                   : {!maj, 1'b0, sr[SW-1:1]};

  assign busy    = (state != S_IDLE);
  assign {rd_ferr, rd_bit9, rd_data} = ent0;
  assign rx_flag = (fcnt != 2'd0);
  assign irq     = int_en & rx_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sync <= 2'b11;
      vote    <= 3'b111;
      prev    <= 1'b1;
    end else begin
      rx_sync <= {rx_sync[0], rx_in};
      if (tick) begin
        vote <= vnext;
        prev <= rx_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
    end else if (tick) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= CW'(1);
          if (prev && !rx_s) state <= S_START;
        end
        S_START: begin
          if (at_vote && maj) state <= S_IDLE;
          else if (at_end) begin
            state <= S_DATA;
            bitn  <= '0;
          end
        end
        S_DATA: begin
          if (at_end) begin
            if (bitn == last) state <= S_STOP;
            else bitn <= bitn + 1'b1;
          end
        end
        S_STOP: if (at_vote) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (tick && state == S_DATA && at_vote) sr <= {maj, sr[SW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
      ent0 <= '0;
      ent1 <= '0;
    end else begin
      if (push && pop_ok) begin
        ent0 <= word;
      end else if (push) begin
        if (fcnt == 2'd0) ent0 <= word;
        else ent1 <= word;
        fcnt <= fcnt + 1'b1;
      end else if (pop_ok) begin
        ent0 <= ent1;
        fcnt <= fcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) overrun <= 1'b0;
    else if (done && full) overrun <= 1'b1;
  end
endmodule

// File: rtl/uart_rx2q_chk.sv
module uart_rx2q_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       pop,
  input logic       push,
  input logic       overrun,
  input logic       rx_flag,
  input logic [1:0] fcnt,
  input logic       busy
);
  AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (rst) fcnt <= 2'd2);                                 // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) overrun && rx_en |=> overrun);                  // R8
  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (rst) overrun && !pop |=> fcnt <= $past(fcnt));      // R9
  AST_OVR_CLEAR:  assert property (@(posedge clk) disable iff (rst) !rx_en |=> !overrun);                          // R10
  AST_IDLE_OFF:   assert property (@(posedge clk) disable iff (rst) !rx_en |=> !busy);                             // R10
  AST_FLAG_DROP:  assert property (@(posedge clk) disable iff (rst) rx_flag && pop && fcnt == 2'd1 && !push |=> !rx_flag); // R11
  AST_EMPTY_POP:  assert property (@(posedge clk) disable iff (rst) !rx_flag && pop && !push |=> !rx_flag);         // R12
endmodule

bind uart_rx2q uart_rx2q_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .pop(pop), .push(push),
  .overrun(overrun), .rx_flag(rx_flag), .fcnt(fcnt), .busy(busy)
);

// File: tb/tb_uart_rx2q.sv
module tb_uart_rx2q;
  logic clk = 1'b0, rst = 1'b1, tick, rx_in = 1'b1, rx_en = 1'b0;
  logic nine_en = 1'b0, int_en = 1'b1, pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, rx_flag, overrun, irq;
  logic [1:0] divc = 2'd0;
  int nchk = 0, nfail = 0;
  bit ended = 0;

  always #2 clk = ~clk;
  always @(posedge clk) divc <= divc + 2'd1;
  assign tick = (divc == 2'd0);

  uart_rx2q dut (.*);

  // fields: nine, stop, din[8:0], exp_data[7:0], exp_b9, exp_fe
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 1'b1, 9'h0A5, 8'hA5, 1'b0, 1'b0},
    {1'b0, 1'b1, 9'h000, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 9'h0FF, 8'hFF, 1'b0, 1'b0},
    {1'b1, 1'b1, 9'h113, 8'h13, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h0EE, 8'hEE, 1'b0, 1'b0},
    {1'b0, 1'b0, 9'h03C, 8'h3C, 1'b0, 1'b1},
    {1'b1, 1'b0, 9'h181, 8'h81, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic stopv, input logic [8:0] d, input int gbit);
    nine_en = nine;
    hold(1'b1, 4);
    hold(1'b0, 16);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      if (i == gbit) begin
        hold(d[i], 8); hold(~d[i], 1); hold(d[i], 7);
      end else hold(d[i], 16);
    end
    hold(stopv, 16);
    hold(1'b1, 8);
  endtask

  task automatic do_pop;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rx_flag", rx_flag, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", irq, 0);
    rst = 1'b0;
    rx_en = 1'b1;
    repeat (8) @(negedge clk);

    for (int k = 0; k < 7; k++) begin
      send(VEC[k][20], VEC[k][19], VEC[k][18:10], -1);
      chk("R2 flag", rx_flag, 1);
      chk("R2 data", rd_data, VEC[k][9:2]);
      chk("R3 bit9", rd_bit9, VEC[k][1]);
      chk("R6 ferr", rd_ferr, VEC[k][0]);
      chk("R11 irq", irq, 1);
      do_pop();
      chk("R11 empty", rx_flag, 0);
    end

    do_pop();
    chk("R12 flag after empty pop", rx_flag, 0);
    chk("R12 overrun", overrun, 0);
    send(1'b0, 1'b1, 9'h05A, -1);
    chk("R12 next word", rd_data, 8'h5A);
    int_en = 1'b0;
    @(negedge clk);
    chk("R11 irq masked", irq, 0);
    int_en = 1'b1;
    do_pop();

    send(1'b0, 1'b1, 9'h05A, 3);
    chk("R5 glitch bit3", rd_data, 8'h5A);
    do_pop();
    send(1'b0, 1'b1, 9'h0C3, 6);
    chk("R5 glitch bit6", rd_data, 8'hC3);
    do_pop();

    hold(1'b0, 5);
    hold(1'b1, 200);
    chk("R4 false start", rx_flag, 0);

    send(1'b1, 1'b1, 9'h1A0, -1);
    send(1'b1, 1'b0, 9'h04B, -1);
    chk("R7 head data", rd_data, 8'hA0);
    chk("R7 head bit9", rd_bit9, 1);
    chk("R7 head ferr", rd_ferr, 0);
    do_pop();
    chk("R7 next data", rd_data, 8'h4B);
    chk("R7 next bit9", rd_bit9, 0);
    chk("R7 next ferr", rd_ferr, 1);
    do_pop();

    send(1'b0, 1'b1, 9'h011, -1);
    send(1'b0, 1'b1, 9'h022, -1);
    chk("R8 no overrun at two", overrun, 0);
    send(1'b0, 1'b1, 9'h033, -1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 head kept", rd_data, 8'h11);
    do_pop();
    chk("R8 second kept", rd_data, 8'h22);
    do_pop();
    chk("R8 third lost", rx_flag, 0);
    send(1'b0, 1'b1, 9'h044, -1);
    chk("R9 blocked", rx_flag, 0);
    chk("R9 still overrun", overrun, 1);

    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 overrun cleared", overrun, 0);
    send(1'b0, 1'b1, 9'h055, -1);
    chk("R10 disabled no word", rx_flag, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    send(1'b0, 1'b1, 9'h066, -1);
    chk("R10 re-enabled flag", rx_flag, 1);
    chk("R10 re-enabled data", rd_data, 8'h66);
    do_pop();

    finish_run();
  end
endmodule